// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets a host run a single serial-flash transaction by writing a few 32-bit registers. The host loads a flash address and, when needed, a word of outgoing data, then writes one command word. That word holds an opcode and three byte counts: address bytes, bytes to write and bytes to read. The engine lowers chip select and sends the opcode, the address bytes and the write bytes on a one-bit SPI link. It then clocks in the requested read bytes and raises chip select again.

Received bytes are packed into 32-bit words and queued in a word FIFO. The host drains the FIFO through a data register, one word per read. A status register reports the FIFO fill in words, whether a transaction is in flight, and four device-state flags supplied from outside. A short status-read command brings the flash status byte back in the top byte of the popped word. Bit 0 of that byte is the write-in-progress flag. Software checks it before it starts a fast read.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, the command, address and write-data registers read as zero, the FIFO is empty and the busy bit is 0.
- R2: A write to offset 0x000 with bit 31 set starts a transaction. The fields are opcode [7:0], address count [11:8], read count [20:12] and write count [29:21]. On the wire the opcode goes first, then the address bytes, then the write bytes, then the read bytes, for 1+A+W+R bytes in total. A write with bit 31 clear only stores the word and starts nothing.
- R3: Bit 31 of the command register reads 1 while a transaction runs and clears itself at the same clock edge that raises chip select.
- R4: The address register (0x004) keeps bits [31:8]. Address bytes go out most significant first: [31:24], [23:16], [15:8]. The fourth address byte is a zero dummy byte, and any further address bytes are also zero.
- R5: Write bytes come from the write-data register (0x00C), starting at [31:24] and moving down one byte at a time. After the fourth byte the order wraps back to [31:24].
- R6: Received bytes are packed with the first byte in [31:24]. A full word, or the last byte of the transaction, pushes the word into a 32-word FIFO, with unfilled low bytes left at zero. Words that arrive while the FIFO is full are dropped.
- R7: The status register (0x014) holds the good flag in bit 0, bad in bit 1, present in bit 2, init-done in bit 3, busy in bit 4, the FIFO word count in bits [10:5], and zero above.
- R8: A read of 0x010 pops one word. Reading an empty FIFO returns zero and leaves the count at zero.
- R9: A command write that arrives while bit 31 is set is ignored. The running transaction and the stored command are unchanged.
- R10: The link uses SPI mode 0 with MSB first. The SCK period is SCK_DIV system clocks, MOSI changes only while SCK is low, and chip select rises SCK_DIV clocks after the last falling SCK edge.
- R11: A status-read command (opcode 0x05, read count 4, no address) returns the flash status byte in bits [31:24] of the popped word, so bit 24 is the write-in-progress flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid on the next cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, registered |
| flash_ok | input | 1 | Device good flag, shown in status bit 0 |
| flash_bad | input | 1 | Device bad flag, shown in status bit 1 |
| flash_present | input | 1 | Device present flag, shown in status bit 2 |
| flash_ready | input | 1 | Device init-done flag, shown in status bit 3 |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A table of commands covers the main combinations. An opcode-only command and a status read isolate the opcode and read paths. A fast read with four address bytes and an odd-length read add the dummy byte and a zero-filled partial word. A write with six bytes tests the wrap of the byte order, and a command with six address bytes tests zero padding past the dummy byte. A 128-byte read fills the FIFO exactly, and a 136-byte read shows that words past the 32nd are dropped. The responder returns a different value for each byte position, so any swap, shift or miscounted phase boundary shows up as a mismatch.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_ADDR  = 8'h04;
  localparam logic [7:0] OFF_WDATA = 8'h0C;
  localparam logic [7:0] OFF_RDATA = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h14;

  typedef struct packed {
    logic       act;
    logic       rsv;
    logic [8:0] wcnt;
    logic [8:0] rcnt;
    logic [3:0] acnt;
    logic [7:0] op;
  } cmd_word_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_WAIT,
    SQ_TAIL
  } seq_state_t;
endpackage

// File: rtl/sfe_byte_shifter.sv
module sfe_byte_shifter #(
  parameter int SCK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HALF = SCK_DIV / 2;
  localparam int HC_W = $clog2(HALF) + 1;

  logic [7:0]      tx_q, rx_q;
  logic [2:0]      bit_q;
  logic [HC_W-1:0] hc_q;
  logic            busy_q, sck_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      hc_q   <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          tx_q   <= tx_byte;
          bit_q  <= '0;
          hc_q   <= '0;
          sck_q  <= 1'b0;
        end
      end else if (hc_q == HC_W'(HALF - 1)) begin
        hc_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        hc_q <= hc_q + HC_W'(1);
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = busy_q ? tx_q[7] : 1'b0;
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R10: mode 0, data may only move while the clock is low
  assert_mosi_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (sck_q && $past(sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/sfe_word_fifo.sv
module sfe_word_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rd_data <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + AW'(1);
      if (do_pop)  rptr_q <= rptr_q + AW'(1);
      if (pop)     rd_data <= do_pop ? mem[rptr_q] : '0;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign count = cnt_q;

  assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && rd_data == '0));
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfe_pkg::*;
#(
  parameter int SCK_DIV    = 4,
  parameter int FIFO_BYTES = 128,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flash_ok,
  input  logic              flash_bad,
  input  logic              flash_present,
  input  logic              flash_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int FIFO_WORDS = FIFO_BYTES / 4;
  localparam int CNT_W      = $clog2(FIFO_WORDS + 1);
  localparam int IDX_W      = 11;
  localparam int TAIL_W     = $clog2(SCK_DIV);

  cmd_word_t         cmd_q;
  logic [31:0]       addr_q, wdat_q, acc_q, acc_nx;
  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q, a_end, w_end, last_idx, a_pos;
  logic [TAIL_W-1:0] tail_q;
  logic              cs_n_q;
  logic [1:0]        w_lane, r_lane;
  logic              in_read;
  logic              sh_start, sh_done;
  logic [7:0]        sh_tx, sh_rx;
  logic              fifo_push, fifo_pop;
  logic [31:0]       fifo_q;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              wr_cmd, wr_addr, wr_wdat;
  logic              rd_fifo_q;
  logic [31:0]       reg_rdata_q, stat_word;

  assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign wr_addr  = bus_wr && (bus_addr == ADDR_W'(OFF_ADDR));
  assign wr_wdat  = bus_wr && (bus_addr == ADDR_W'(OFF_WDATA));
  assign fifo_pop = bus_rd && (bus_addr == ADDR_W'(OFF_RDATA));

  // byte index decode: 0 = opcode, then address, write, read
  always_comb begin
    a_end    = IDX_W'(cmd_q.acnt);
    w_end    = a_end + IDX_W'(cmd_q.wcnt);
    last_idx = w_end + IDX_W'(cmd_q.rcnt);
    a_pos    = idx_q - IDX_W'(1);
    w_lane   = 2'(idx_q - IDX_W'(1) - a_end);
    r_lane   = 2'(idx_q - IDX_W'(1) - w_end);
    in_read  = idx_q > w_end;
    if (idx_q == '0)
      sh_tx = cmd_q.op;
    else if (idx_q <= a_end)
      sh_tx = (a_pos < IDX_W'(3)) ? 8'(addr_q >> (24 - 8 * a_pos[1:0])) : 8'h00;
    else if (!in_read)
      sh_tx = 8'(wdat_q >> (24 - 8 * w_lane));
    else
      sh_tx = 8'h00;
    acc_nx = acc_q | ({sh_rx, 24'h0} >> (8 * r_lane));
  end

  assign sh_start  = (state_q == SQ_LOAD);
  assign fifo_push = sh_done && (state_q == SQ_WAIT) && in_read &&
                     ((r_lane == 2'd3) || (idx_q == last_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      tail_q  <= '0;
      acc_q   <= '0;
      cs_n_q  <= 1'b1;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (wr_cmd) begin
            cmd_q <= cmd_word_t'(bus_wdata);
            if (bus_wdata[31]) begin
              state_q <= SQ_LOAD;
              idx_q   <= '0;
              acc_q   <= '0;
              cs_n_q  <= 1'b0;
            end
          end
        end
        SQ_LOAD: state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (sh_done) begin
            if (in_read) acc_q <= fifo_push ? 32'h0 : acc_nx;
            if (idx_q == last_idx) begin
              state_q <= SQ_TAIL;
              tail_q  <= '0;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= SQ_LOAD;
            end
          end
        end
        default: begin
          if (tail_q == TAIL_W'(SCK_DIV - 2)) begin
            cs_n_q    <= 1'b1;
            cmd_q.act <= 1'b0;
            state_q   <= SQ_IDLE;
          end else begin
            tail_q <= tail_q + TAIL_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      if (wr_addr) addr_q <= {bus_wdata[31:8], 8'h00};
      if (wr_wdat) wdat_q <= bus_wdata;
    end
  end

  assign stat_word = {21'h0, 6'(fifo_cnt), cmd_q.act,
                      flash_ready, flash_present, flash_bad, flash_ok};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_fifo_q   <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      rd_fifo_q <= fifo_pop;
      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(OFF_CMD):   reg_rdata_q <= cmd_q;
          ADDR_W'(OFF_ADDR):  reg_rdata_q <= addr_q;
          ADDR_W'(OFF_WDATA): reg_rdata_q <= wdat_q;
          ADDR_W'(OFF_STAT):  reg_rdata_q <= stat_word;
          default:            reg_rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_fifo_q ? fifo_q : reg_rdata_q;
  assign spi_cs_n  = cs_n_q;

  sfe_byte_shifter #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  sfe_word_fifo #(.DEPTH(FIFO_WORDS), .W(32)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (fifo_push),
    .push_data (acc_nx),
    .pop       (fifo_pop),
    .rd_data   (fifo_q),
    .count     (fifo_cnt)
  );

  assert_cs_needs_active_R3: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> cmd_q.act);
  assert_sck_inside_cs_R10: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n);
  assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && cmd_q.act && state_q != SQ_TAIL) |=> $stable(cmd_q));
endmodule

// File: tb/sflash_cmd_engine_bench.sv
module sflash_cmd_engine_bench;
  localparam int SCK_DIV = 4;

  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  ac;
    logic [8:0]  rn;
    logic [8:0]  wn;
    logic [23:0] ad;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h05, 4'd0, 9'd4,   9'd0, 24'h000000, 32'h00000000},
    '{8'h0B, 4'd4, 9'd8,   9'd0, 24'h123456, 32'h00000000},
    '{8'h02, 4'd3, 9'd0,   9'd6, 24'hABCDEF, 32'hDEADBEEF},
    '{8'h9F, 4'd0, 9'd3,   9'd0, 24'h000000, 32'h00000000},
    '{8'h0B, 4'd4, 9'd128, 9'd0, 24'h000100, 32'h00000000},
    '{8'h03, 4'd3, 9'd136, 9'd0, 24'h00FF00, 32'h00000000},
    '{8'h06, 4'd0, 9'd0,   9'd0, 24'h000000, 32'h00000000},
    '{8'h0B, 4'd6, 9'd5,   9'd1, 24'h010203, 32'hA1000000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic flash_ok = 1'b1, flash_bad = 1'b0, flash_present = 1'b1, flash_ready = 1'b1;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sflash_cmd_engine #(.SCK_DIV(SCK_DIV)) u_sflash_cmd_engine (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_ok(flash_ok),
    .flash_bad(flash_bad), .flash_present(flash_present), .flash_ready(flash_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash responder, sampled mid-cycle
  logic [7:0] mlog [16];
  logic [7:0] sh = '0;
  logic [7:0] stat_byte = 8'h03;
  int rc = 0, oidx = 0, ntx = 0, nbytes = 0, nrem = 0;
  int rise1 = 0, rise2 = 0, last_fall = 0, cs_rise = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  function automatic logic [7:0] exp_rb(logic [7:0] op, int n);
    return (op == 8'h05) ? stat_byte : 8'(8'h30 + n * 7);
  endfunction

  function automatic logic miso_bit(int o);
    logic [7:0] b;
    b = exp_rb(mlog[0], o / 8);
    return b[7 - (o % 8)];
  endfunction

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin rc = 0; oidx = 0; ntx = ntx + 1; end
    if (!prev_sck && spi_sck) begin
      if (rc == 0) rise1 = cyc;
      if (rc == 1) rise2 = cyc;
      sh = {sh[6:0], spi_mosi};
      if (rc % 8 == 7 && rc / 8 < 16) mlog[rc / 8] = sh;
      rc = rc + 1;
    end
    if (prev_sck && !spi_sck) begin oidx = rc; last_fall = cyc; end
    if (!prev_cs && spi_cs_n) begin cs_rise = cyc; nbytes = rc / 8; nrem = rc % 8; end
    spi_miso = miso_bit(oidx);
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      bus_read(8'h00, v);
      if (!v[31]) return;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, ew;
    int tx0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(spi_cs_n === 1'b1, "R1 cs_n idle", {31'h0, spi_cs_n}, 32'h1);
    check(spi_sck === 1'b0, "R1 sck idle", {31'h0, spi_sck}, 32'h0);
    bus_read(8'h00, v); check(v == 32'h0, "R1 cmd reg", v, 32'h0);
    bus_read(8'h04, v); check(v == 32'h0, "R1 addr reg", v, 32'h0);
    bus_read(8'h0C, v); check(v == 32'h0, "R1 wdata reg", v, 32'h0);
    bus_read(8'h14, v); check(v == 32'h0000000D, "R1 R7 status after reset", v, 32'h0000000D);

    // R7 flags follow inputs
    flash_ok = 1'b0; flash_bad = 1'b1; flash_present = 1'b0; flash_ready = 1'b0;
    bus_read(8'h14, v); check(v == 32'h00000002, "R7 flag bits", v, 32'h2);
    flash_ok = 1'b1; flash_bad = 1'b0; flash_present = 1'b1; flash_ready = 1'b1;

    // R8 pop from empty FIFO
    bus_read(8'h10, v); check(v == 32'h0, "R8 empty pop data", v, 32'h0);
    bus_read(8'h14, v); check(v[10:5] == 6'd0, "R8 count after empty pop", {26'h0, v[10:5]}, 32'h0);

    // R2 store without start
    tx0 = ntx;
    bus_write(8'h00, 32'h00000006);
    repeat (20) @(negedge clk);
    check(ntx == tx0, "R2 no start without bit31", ntx, tx0);
    bus_read(8'h00, v); check(v == 32'h00000006, "R2 stored command", v, 32'h6);

    // vector table
    for (int k = 0; k < NV; k++) begin
      automatic vec_t t = VECS[k];
      automatic int nw;
      bus_write(8'h04, {t.ad, 8'h5A});
      bus_write(8'h0C, t.wd);
      bus_write(8'h00, {1'b1, 1'b0, t.wn, t.rn, t.ac, t.op});
      wait_idle();
      repeat (2) @(negedge clk);
      check(nbytes == 1 + int'(t.ac) + int'(t.wn) + int'(t.rn) && nrem == 0,
            "R2 byte count", nbytes, 1 + t.ac + t.wn + t.rn);
      check(mlog[0] == t.op, "R2 opcode first", mlog[0], t.op);
      for (int i = 0; i < int'(t.ac); i++) begin
        automatic logic [7:0] e = (i < 3) ? 8'(t.ad >> (16 - 8 * i)) : 8'h00;
        check(mlog[1 + i] == e, "R4 address byte", mlog[1 + i], e);
      end
      for (int j = 0; j < int'(t.wn); j++) begin
        automatic int p = 1 + int'(t.ac) + j;
        automatic logic [7:0] e = 8'(t.wd >> (24 - 8 * (j % 4)));
        if (p < 16) check(mlog[p] == e, "R5 write byte", mlog[p], e);
      end
      nw = (int'(t.rn) + 3) / 4;
      if (nw > 32) nw = 32;
      bus_read(8'h14, v);
      check(v[10:5] == 6'(nw) && v[4] == 1'b0, "R6 R7 FIFO count", {26'h0, v[10:5]}, nw);
      for (int w = 0; w < nw; w++) begin
        ew = '0;
        for (int l = 0; l < 4; l++) begin
          automatic int b = 4 * w + l;
          if (b < int'(t.rn))
            ew = ew | ({exp_rb(t.op, 1 + int'(t.ac) + int'(t.wn) + b), 24'h0} >> (8 * l));
        end
        bus_read(8'h10, v);
        check(v == ew, "R6 read word", v, ew);
        if (t.op == 8'h05)
          check(v[31:24] == stat_byte && v[24] == 1'b1, "R11 status byte and WIP", v, ew);
      end
      bus_read(8'h14, v); check(v[10:5] == 6'd0, "R8 FIFO drained", {26'h0, v[10:5]}, 32'h0);
    end

    // R3 / R9 / R10 directed
    bus_write(8'h04, 32'h00200000);
    bus_write(8'h00, {1'b1, 1'b0, 9'd0, 9'd16, 4'd4, 8'h0B});
    bus_read(8'h00, v); check(v[31] == 1'b1, "R3 active while running", v, 32'h8000000B);
    bus_read(8'h14, v); check(v[4] == 1'b1, "R3 R7 busy bit", v, 32'h10);
    bus_write(8'h00, {1'b1, 1'b0, 9'd0, 9'd1, 4'd0, 8'h9F});
    bus_read(8'h00, v); check(v[7:0] == 8'h0B, "R9 command kept", v[7:0], 8'h0B);
    @(posedge spi_cs_n);
    @(negedge clk);
    bus_read(8'h00, v); check(v[31] == 1'b0, "R3 active cleared", v, 32'h0);
    check(cs_rise - last_fall == SCK_DIV, "R10 cs rise delay", cs_rise - last_fall, SCK_DIV);
    check(rise2 - rise1 == SCK_DIV, "R10 SCK period", rise2 - rise1, SCK_DIV);
    check(mlog[0] == 8'h0B && nbytes == 21, "R9 ignored command did not run", nbytes, 21);
    bus_read(8'h14, v); check(v[10:5] == 6'd4, "R9 FIFO from first command", {26'h0, v[10:5]}, 4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule